// File: doc/BRIEF.md
# Data Access Address Translation and Fault Decision

This unit sits after the data-side TLB lookup of a load/store pipeline. It takes a data virtual address with its access size, direction and mode context, together with the TLB result for that address. From these it produces the physical address, an uncacheable marker and a single fault decision. The fault decision carries a fault type and a six-bit status word that the fault handler receives.

Each request is evaluated in one cycle and registered. The checks run in a fixed order: alignment first, then the physical bypass, virtual-range validity, the kernel-only superpage window, TLB miss, permission and fault-on bits, and last the implemented-physical-range check. Only the first failing check is reported.

The effective privilege mode normally comes from the current-mode input. While privileged code runs, it comes from the alternate-mode input when the alternate flag is set, and is kernel otherwise.

Top module: `xlate_check`

## Requirements
- R1: A request captured on a rising edge with `req_valid` high appears on the outputs after that edge with `rsp_valid` high. Reset clears `rsp_valid`, `rsp_fault`, `rsp_uncached`, `rsp_ftype` (0 = none) and `rsp_status`.
- R2: If the address is not a multiple of 2^`size_log2` bytes, the fault type is 1 (alignment). This check outranks every other. The status holds only bit 0 (write), and only for stores.
- R3: The effective mode is `cur_mode` when `priv_code` is low. When `priv_code` is high it is `alt_mode` if `alt_flag` is high, and kernel (0) otherwise. Mode codes are 0 kernel, 1 executive, 2 supervisor and 3 user, and mode m selects bit m of the permission masks.
- R4: With `phys` high, the physical address equals the virtual address. No range, superpage, TLB or permission check is made.
- R5: A virtual address whose bits 63:47 are not all equal gives fault type 2 (page fault). Its status has bit 2 (bad address) and bit 1 (access violation) set, plus bit 0 for stores.
- R6: An address with bits 47:41 equal to 0x7e is a superpage access and skips the TLB. If `cur_mode` is not kernel, it gives fault type 3 (access violation) with status bit 1, plus bit 0 for stores.
- R7: For a superpage access, the physical address is the virtual address masked to bits 43:0. If bit 40 of that value is set, bits 43:40 are forced to one; otherwise only bits 39:0 are kept.
- R8: A TLB miss gives fault type 4, or type 5 when `pte_fetch` is high. The status has bit 3 (miss) set, plus bit 0 for stores.
- R9: On a TLB hit, the physical address is `tlb_ppn` shifted left by 13 bits, plus the low 13 bits of the virtual address.
- R10: A store whose write-mask bit for the effective mode is clear gives type 2 with status bits 0 and 1, plus bit 5 if `tlb_fow` is set. Otherwise a set `tlb_fow` alone gives type 2 with bits 0 and 5.
- R11: A load whose read-mask bit for the effective mode is clear gives type 3 with status bit 1, plus bit 4 if `tlb_for` is set. Otherwise a set `tlb_for` alone gives type 2 with bit 4.
- R12: If no earlier fault occurred and the physical address has any bit above bit 43 set, the result is fault type 6 (machine check) with a zero status.
- R13: `rsp_uncached` is high exactly when no fault is reported and physical bit 43 is set. `rsp_fault` is high exactly when the fault type is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| va | input | 64 | Data virtual address |
| size_log2 | input | 2 | Access size as log2 of bytes |
| is_write | input | 1 | Store when high, load when low |
| phys | input | 1 | Physical bypass |
| priv_code | input | 1 | Privileged code is running |
| alt_flag | input | 1 | Use alternate mode while privileged |
| cur_mode | input | 2 | Current mode register |
| alt_mode | input | 2 | Alternate mode register |
| pte_fetch | input | 1 | Access is a page-table-entry fetch |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_ppn | input | 51 | Physical page number from the TLB |
| tlb_rd_en | input | 4 | Read-permission mask, one bit per mode |
| tlb_wr_en | input | 4 | Write-permission mask, one bit per mode |
| tlb_for | input | 1 | Fault-on-read bit |
| tlb_fow | input | 1 | Fault-on-write bit |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 64 | Physical address, meaningful when no fault |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_fault | output | 1 | A fault is reported |
| rsp_ftype | output | 3 | Fault type code |
| rsp_status | output | 6 | Status word: 0 write, 1 violation, 2 bad address, 3 miss, 4 fault-on-read, 5 fault-on-write |

## Verification
The hardest case to reach from the ports is an address that would fail several checks at once. Only the ordering decides which fault appears there, for example a misaligned superpage access from user mode, or a store lacking write permission whose fault-on-write bit is also set. The bench sweeps a combined grid of size, offset, mode context and permission/fault-on bits. At each point it computes the single expected fault from the requirement order, so every overlap of two failing checks is compared. The sign-extension branch of the superpage mapping is reached by choosing bit 40 of the address both ways.

// File: rtl/xlate_check.sv
module xlate_check #(
  parameter int VA_W      = 64,
  parameter int VA_IMPL_W = 48,
  parameter int PA_IMPL_W = 44,
  parameter int PAGE_BITS = 13,
  parameter int SP_TOP    = 47,
  parameter int SP_BOT    = 41,
  parameter logic [SP_TOP-SP_BOT:0] SP_TAG = 'h7e,
  parameter int SP_EXT    = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           va,
  input  logic [1:0]                size_log2,
  input  logic                      is_write,
  input  logic                      phys,
  input  logic                      priv_code,
  input  logic                      alt_flag,
  input  logic [1:0]                cur_mode,
  input  logic [1:0]                alt_mode,
  input  logic                      pte_fetch,
  input  logic                      tlb_hit,
  input  logic [VA_W-PAGE_BITS-1:0] tlb_ppn,
  input  logic [3:0]                tlb_rd_en,
  input  logic [3:0]                tlb_wr_en,
  input  logic                      tlb_for,
  input  logic                      tlb_fow,
  output logic                      rsp_valid,
  output logic [VA_W-1:0]           rsp_pa,
  output logic                      rsp_uncached,
  output logic                      rsp_fault,
  output logic [2:0]                rsp_ftype,
  output logic [5:0]                rsp_status
);
  localparam logic [2:0] F_NONE = 3'd0, F_ALIGN = 3'd1, F_PAGE = 3'd2, F_ACV = 3'd3,
                         F_MISS = 3'd4, F_PTE = 3'd5, F_MCHK = 3'd6;
  localparam int S_WR = 0, S_ACV = 1, S_BAD = 2, S_MISS = 3, S_FOR = 4, S_FOW = 5;
  localparam logic [VA_W-1:0] IMPL_MASK = (VA_W'(1) << PA_IMPL_W) - 1;
  localparam logic [VA_W-1:0] LOW_MASK  = (VA_W'(1) << SP_EXT) - 1;
  localparam logic [VA_W-1:0] EXT_ONES  = IMPL_MASK & ~LOW_MASK;

  logic [1:0]      mode_eff;
  logic [VA_W-1:0] size_mask, sp_raw, sp_pa, hit_pa, pa_n;
  logic            misalign, va_ok, is_sp;
  logic [2:0]      ft_n;
  logic [5:0]      st_n;

  assign mode_eff  = priv_code ? (alt_flag ? alt_mode : 2'd0) : cur_mode;
  assign size_mask = (VA_W'(1) << size_log2) - VA_W'(1);
  assign misalign  = |(va & size_mask);
  assign va_ok     = (&va[VA_W-1:VA_IMPL_W-1]) | ~(|va[VA_W-1:VA_IMPL_W-1]);
  assign is_sp     = va[SP_TOP:SP_BOT] == SP_TAG;
  assign sp_raw    = va & IMPL_MASK;
  assign sp_pa     = sp_raw[SP_EXT] ? (sp_raw | EXT_ONES) : (sp_raw & LOW_MASK);
  assign hit_pa    = {tlb_ppn, va[PAGE_BITS-1:0]};

  always_comb begin
    ft_n = F_NONE;
    st_n = '0;
    pa_n = '0;
    if (misalign) begin
      ft_n = F_ALIGN;
      st_n[S_WR] = is_write;
    end else if (phys) begin
      pa_n = va;
    end else if (!va_ok) begin
      ft_n = F_PAGE;
      st_n[S_WR] = is_write;
      st_n[S_BAD] = 1'b1;
      st_n[S_ACV] = 1'b1;
    end else if (is_sp) begin
      if (cur_mode != 2'd0) begin
        ft_n = F_ACV;
        st_n[S_WR] = is_write;
        st_n[S_ACV] = 1'b1;
      end else begin
        pa_n = sp_pa;
      end
    end else if (!tlb_hit) begin
      ft_n = pte_fetch ? F_PTE : F_MISS;
      st_n[S_WR] = is_write;
      st_n[S_MISS] = 1'b1;
    end else begin
      pa_n = hit_pa;
      if (is_write) begin
        if (!tlb_wr_en[mode_eff]) begin
          ft_n = F_PAGE;
          st_n[S_WR] = 1'b1;
          st_n[S_ACV] = 1'b1;
          st_n[S_FOW] = tlb_fow;
        end else if (tlb_fow) begin
          ft_n = F_PAGE;
          st_n[S_WR] = 1'b1;
          st_n[S_FOW] = 1'b1;
        end
      end else begin
        if (!tlb_rd_en[mode_eff]) begin
          ft_n = F_ACV;
          st_n[S_ACV] = 1'b1;
          st_n[S_FOR] = tlb_for;
        end else if (tlb_for) begin
          ft_n = F_PAGE;
          st_n[S_FOR] = 1'b1;
        end
      end
    end
    if (ft_n == F_NONE && |(pa_n & ~IMPL_MASK)) begin
      ft_n = F_MCHK;
      st_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_pa       <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_ftype    <= F_NONE;
      rsp_status   <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_pa       <= pa_n;
      rsp_uncached <= req_valid && ft_n == F_NONE && pa_n[PA_IMPL_W-1];
      rsp_fault    <= req_valid && ft_n != F_NONE;
      rsp_ftype    <= req_valid ? ft_n : F_NONE;
      rsp_status   <= req_valid ? st_n : '0;
    end
  end

  assert_align_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && |(va & ((VA_W'(1) << size_log2) - VA_W'(1))))
      |=> (rsp_fault && rsp_ftype == F_ALIGN && (rsp_status & ~6'b1) == '0));

  assert_bypass_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && phys && !(|(va & ((VA_W'(1) << size_log2) - VA_W'(1)))) && va[VA_W-1:PA_IMPL_W] == '0)
      |=> (!rsp_fault && rsp_pa == $past(va)));

  assert_single_fault_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault == (rsp_ftype != F_NONE));

  assert_uncached_clean_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncached |-> (!rsp_fault && rsp_pa[PA_IMPL_W-1]));

  assert_miss_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_status[S_MISS] |-> (rsp_ftype == F_MISS || rsp_ftype == F_PTE));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_status == '0));
endmodule

// File: tb/tb_xlate_check.sv
module tb_xlate_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] va = '0;
  logic [1:0]  size_log2 = '0;
  logic        is_write = 1'b0, phys = 1'b0, priv_code = 1'b0, alt_flag = 1'b0;
  logic [1:0]  cur_mode = '0, alt_mode = '0;
  logic        pte_fetch = 1'b0, tlb_hit = 1'b0;
  logic [50:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
  logic        tlb_for = 1'b0, tlb_fow = 1'b0;
  logic        rsp_valid, rsp_uncached, rsp_fault;
  logic [63:0] rsp_pa;
  logic [2:0]  rsp_ftype;
  logic [5:0]  rsp_status;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlate_check dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va), .size_log2(size_log2),
    .is_write(is_write), .phys(phys), .priv_code(priv_code), .alt_flag(alt_flag),
    .cur_mode(cur_mode), .alt_mode(alt_mode), .pte_fetch(pte_fetch), .tlb_hit(tlb_hit),
    .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en), .tlb_for(tlb_for),
    .tlb_fow(tlb_fow), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached),
    .rsp_fault(rsp_fault), .rsp_ftype(rsp_ftype), .rsp_status(rsp_status));

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference computed from the requirement list, first failing check wins.
  task automatic expect_result(output logic [2:0] ft, output logic [5:0] st,
                               output logic [63:0] pa, output logic unc);
    logic [1:0]  m;
    logic [63:0] raw;
    ft = 0; st = 0; pa = 0;
    m = !priv_code ? cur_mode : (alt_flag ? alt_mode : 2'd0);
    if ((va % (64'd1 << size_log2)) != 0) begin ft = 1; st = {5'd0, is_write}; end
    else if (phys) pa = va;
    else if (!(va[63:47] == '0 || va[63:47] == '1)) begin ft = 2; st = 6'b000110 | {5'd0, is_write}; end
    else if (va[47:41] == 7'h7e) begin
      if (cur_mode != 0) begin ft = 3; st = 6'b000010 | {5'd0, is_write}; end
      else begin
        raw = va % (64'd1 << 44);
        pa = raw[40] ? (raw | (64'hF << 40)) : (raw % (64'd1 << 40));
      end
    end
    else if (!tlb_hit) begin ft = pte_fetch ? 5 : 4; st = 6'b001000 | {5'd0, is_write}; end
    else begin
      pa = {13'd0, tlb_ppn} * 64'd8192 + (va % 64'd8192);
      if (is_write) begin
        if (!tlb_wr_en[m]) begin ft = 2; st = 6'b000011 | (tlb_fow ? 6'b100000 : 0); end
        else if (tlb_fow) begin ft = 2; st = 6'b100001; end
      end else begin
        if (!tlb_rd_en[m]) begin ft = 3; st = 6'b000010 | (tlb_for ? 6'b010000 : 0); end
        else if (tlb_for) begin ft = 2; st = 6'b010000; end
      end
    end
    if (ft == 0 && (pa >> 44) != 0) begin ft = 6; st = 0; end
    unc = (ft == 0) && pa[43];
  endtask

  task automatic run(input string req);
    logic [2:0] ft; logic [5:0] st; logic [63:0] pa; logic unc;
    expect_result(ft, st, pa, unc);
    req_valid = 1'b1;
    @(negedge clk);
    check({req, " valid"}, {127'd0, rsp_valid}, 128'd1);
    check({req, " ftype"}, {125'd0, rsp_ftype}, {125'd0, ft});
    check({req, " status"}, {122'd0, rsp_status}, {122'd0, st});
    check({req, " uncached"}, {127'd0, rsp_uncached}, {127'd0, unc});
    if (ft == 0) check({req, " pa"}, {64'd0, rsp_pa}, {64'd0, pa});
  endtask

  task automatic clear_ctx();
    phys = 0; priv_code = 0; alt_flag = 0; cur_mode = 0; alt_mode = 0; pte_fetch = 0;
    tlb_hit = 1; tlb_ppn = 51'h1234; tlb_rd_en = 4'hF; tlb_wr_en = 4'hF;
    tlb_for = 0; tlb_fow = 0; is_write = 0; size_log2 = 0; va = 64'h1000;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", {127'd0, rsp_valid}, 128'd0);
    check("R1 reset fault", {127'd0, rsp_fault}, 128'd0);
    check("R1 reset status", {122'd0, rsp_status}, 128'd0);
    rst_n = 1'b1;
    clear_ctx();
    @(negedge clk);
    check("R1 idle valid", {127'd0, rsp_valid}, 128'd0);

    // R2 alignment sweep, including overlap with superpage/user and miss
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o++)
        for (int w = 0; w < 2; w++)
          for (int k = 0; k < 3; k++) begin
            clear_ctx();
            size_log2 = s[1:0]; is_write = w[0];
            va = (k == 2) ? ({16'hFFFF, 7'h7e, 41'h0} + 64'(o)) : (64'h2000 + 64'(o));
            if (k == 1) tlb_hit = 0;
            if (k == 2) cur_mode = 3;
            run("R2 align");
          end

    // R3 effective mode selection, read and write permission per mode
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 2; a++)
        for (int c = 0; c < 4; c++)
          for (int am = 0; am < 4; am++)
            for (int bit_i = 0; bit_i < 4; bit_i++)
              for (int w = 0; w < 2; w++) begin
                clear_ctx();
                priv_code = p[0]; alt_flag = a[0]; cur_mode = c[1:0]; alt_mode = am[1:0];
                is_write = w[0];
                tlb_rd_en = 4'b1 << bit_i; tlb_wr_en = 4'b1 << bit_i;
                run("R3 mode");
              end

    // R4 bypass, R12 machine check, R13 uncached
    for (int b = 40; b < 64; b++) begin
      clear_ctx();
      phys = 1; tlb_hit = 0; va = (64'd1 << b) | 64'h40;
      run("R4 R12 R13 bypass");
    end

    // R5 bad virtual address
    for (int b = 47; b < 64; b++)
      for (int w = 0; w < 2; w++) begin
        clear_ctx();
        is_write = w[0]; va = (64'd1 << b) | 64'h88;
        run("R5 range");
        va = ~(64'd1 << b) & ~64'h7;
        run("R5 range hi");
      end

    // R6 R7 superpage
    for (int c = 0; c < 4; c++)
      for (int e = 0; e < 2; e++)
        for (int w = 0; w < 2; w++) begin
          clear_ctx();
          cur_mode = c[1:0]; is_write = w[0]; tlb_hit = 0;
          priv_code = (c == 1); alt_flag = 1; alt_mode = 0;
          va = {16'hFFFF, 7'h7e, e[0], 40'h12_3456_7890} & ~64'h7;
          run("R6 R7 superpage");
        end

    // R8 miss and page-table-entry miss
    for (int pf = 0; pf < 2; pf++)
      for (int w = 0; w < 2; w++) begin
        clear_ctx();
        tlb_hit = 0; pte_fetch = pf[0]; is_write = w[0]; va = 64'hFFFF_8000_0000_1000;
        run("R8 miss");
      end

    // R9 R10 R11 hit address and permission/fault-on matrix
    for (int w = 0; w < 2; w++)
      for (int en = 0; en < 2; en++)
        for (int fr = 0; fr < 2; fr++)
          for (int fw = 0; fw < 2; fw++) begin
            clear_ctx();
            is_write = w[0]; tlb_rd_en = en[0] ? 4'hF : 4'h0; tlb_wr_en = en[0] ? 4'hF : 4'h0;
            tlb_for = fr[0]; tlb_fow = fw[0]; tlb_ppn = 51'h5_4321; va = 64'h0000_0012_3456_1ABC;
            run("R9 R10 R11 perm");
          end

    // R9 R12 R13 large page numbers
    for (int b = 25; b < 51; b++) begin
      clear_ctx();
      tlb_ppn = 51'd1 << b; va = 64'h1FF8; size_log2 = 3;
      run("R9 R12 R13 ppn");
    end

    req_valid = 1'b0;
    @(negedge clk);
    check("R1 idle after", {127'd0, rsp_valid}, 128'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule